// File: doc/BRIEF.md
# SPI Host Segment Sequencer

This block is the data path of a memory-mapped SPI host. Software writes 32-bit words to a transmit data register. The block splits each word into bytes, least significant byte first, and queues them in a transmit byte FIFO. Received bytes collect in a receive byte FIFO. Software reads them back from a receive data register as 32-bit words, with the oldest byte in the lowest lane.

A write to the command register starts a full-duplex segment. The segment runs up to LEN byte exchanges on a byte-wide shift port that uses a valid/ready handshake. Each completed handshake moves one byte from the transmit FIFO to the shifter and stores the byte returned by the shifter in the receive FIFO. A segment stops early, with a stall flag set, when no transmit byte is available or when the receive FIFO has no room. When the segment ends, any transmit bytes left over are discarded.

Misuse of the bus sets sticky error flags, and software clears them by writing ones. A software reset bit in the control register returns the block to its reset state.

Top module: `spi_seg_host`

## Requirements
- R1: A write to TXDATA (offset 0x24) queues its four bytes in the order bits 7:0, 15:8, 23:16, 31:24, and the shift port presents them in that order.
- R2: The transmit FIFO holds 256 bytes. When it cannot take a whole word, the bytes that do not fit are dropped, TXFULL (STATUS bit 29) is set and OVERFLOW (ERR bit 1, offset 0x30) is set.
- R3: A read of RXDATA (offset 0x28) pops up to four bytes: the oldest byte goes in bits 7:0, the next in bits 15:8, and so on. After the read, RXFULL (STATUS bit 25) is clear.
- R4: If fewer than four bytes are queued when RXDATA is read, the read returns the bytes available with the upper lanes zero, sets UNDERFLOW (ERR bit 2), and RXEMPTY (STATUS bit 24) then reads 1.
- R5: A write to COMMAND (offset 0x20) has no effect while the enable bit (CTRL bit 31, offset 0x10) is clear.
- R6: A command written while READY (STATUS bit 31) is clear sets CMDBUSY (ERR bit 0) and does not start a segment.
- R7: An accepted command clears READY and sets ACTIVE (STATUS bit 30), then performs LEN exchanges, where LEN is COMMAND bits 7:0. Each handshake pops one transmit byte and pushes one received byte. A byte that is offered holds steady until it is accepted.
- R8: A segment that finds the transmit FIFO empty when a byte is due ends and sets TXSTALL (STATUS bit 27). A segment that finds the receive FIFO full ends and sets RXSTALL (STATUS bit 23). The next accepted command clears both flags.
- R9: At the end of a segment READY is set again, and the transmit bytes left over are discarded, so TXEMPTY (STATUS bit 28) reads 1.
- R10: A write to CSID (offset 0x1C) with a value at or above NUM_CS leaves the chip-select index unchanged and sets CSIDINVAL (ERR bit 4).
- R11: Writing CTRL with bit 30 set empties both FIFOs and aborts any segment. It also clears the enable bit, the chip-select index, the error flags and the stall flags.
- R12: STATUS bits 7:0 give the transmit depth and bits 15:8 give the receive depth, both in 32-bit words rounded up.
- R13: Error flags stay set until software writes ERR. Each bit written as 1 clears only the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; the pop caused by an RXDATA read happens at the clock edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| xfer_valid | output | 1 | A transmit byte is offered to the shifter |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ready | input | 1 | The shifter completes the exchange in this cycle |
| xfer_rx | input | 8 | Byte received during the exchange |
| cs_index | output | 2 | Selected chip-select index |

## Verification
The embedded properties check the following on every cycle:
- Neither FIFO count leaves its legal range, and a pop never exceeds what is stored.
- An offered byte stays stable until it is accepted.
- A stall flag is never set while a segment runs.
- Each end of a segment leaves the transmit FIFO empty.
- Rejected command and CSID writes have their effect on the following cycle.
- The software reset empties the FIFOs and ends any segment.

Other behaviour can only be shown by the bench's scenarios:
- The byte order across a word, and the packing of received words.
- The exact depths rounded up to words.
- Which bytes are exchanged before a stall.
- Partial reads that underflow.
- The selective clearing of error flags.
The bench compares each offered byte against a queue filled by a byte-level model of both FIFOs.

// File: rtl/spi_seg_pkg.sv
package spi_seg_pkg;

  // register byte offsets
  localparam logic [5:0] A_CTRL = 6'h10;
  localparam logic [5:0] A_STAT = 6'h14;
  localparam logic [5:0] A_CSID = 6'h1C;
  localparam logic [5:0] A_CMD  = 6'h20;
  localparam logic [5:0] A_TXD  = 6'h24;
  localparam logic [5:0] A_RXD  = 6'h28;
  localparam logic [5:0] A_ERR  = 6'h30;

  // control bits
  localparam int C_EN  = 31;
  localparam int C_RST = 30;

  // status bits
  localparam int S_READY   = 31;
  localparam int S_ACTIVE  = 30;
  localparam int S_TXFULL  = 29;
  localparam int S_TXEMPTY = 28;
  localparam int S_TXSTALL = 27;
  localparam int S_RXFULL  = 25;
  localparam int S_RXEMPTY = 24;
  localparam int S_RXSTALL = 23;

  // error bits
  localparam int E_BUSY = 0;
  localparam int E_OVF  = 1;
  localparam int E_UNF  = 2;
  localparam int E_CSID = 4;
  localparam int E_W    = 5;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_t;

  // byte count -> whole words, rounded up
  function automatic logic [7:0] words_up(input logic [15:0] nbytes);
    logic [15:0] t;
    t = (nbytes + 16'd3) >> 2;
    return t[7:0];
  endfunction

  // how many bytes of a word fit / can be taken, at most four
  function automatic logic [2:0] up_to_four(input logic [15:0] avail);
    return (avail >= 16'd4) ? 3'd4 : avail[2:0];
  endfunction

endpackage

// File: rtl/spi_seg_fifo.sv
module spi_seg_fifo #(
  parameter int DEPTH  = 256,
  parameter int PUSH_W = 4,
  parameter int POP_W  = 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int PNW = $clog2(PUSH_W + 1),
  localparam int QNW = $clog2(POP_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [PNW-1:0]        push_n,
  input  logic [PUSH_W*8-1:0]   push_data,
  input  logic [QNW-1:0]        pop_n,
  output logic [CW-1:0]         count,
  output logic [POP_W*8-1:0]    peek
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rptr, wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (flush) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + AW'(push_n);
      rptr  <= rptr + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_W; i++) begin
      if (!flush && (i < int'(push_n)))
        mem[wptr + AW'(i)] <= push_data[i*8 +: 8];
    end
  end

  for (genvar j = 0; j < POP_W; j++) begin : g_peek
    assign peek[j*8 +: 8] = mem[rptr + AW'(j)];
  end

  p_fifo_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  p_fifo_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (CW'(pop_n) <= count));

  p_fifo_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (32'(count) + 32'(push_n) <= DEPTH + 32'(pop_n)));

endmodule

// File: rtl/spi_seg_engine.sv
module spi_seg_engine
  import spi_seg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic [7:0]       tx_head,
  input  logic             xfer_ready,
  output logic             xfer_valid,
  output logic [7:0]       xfer_tx,
  output logic             step,
  output logic             busy,
  output logic             seg_done,
  output logic             tx_stall,
  output logic             rx_stall
);

  eng_state_t       state;
  logic [LEN_W-1:0] remain;
  logic             hit_tx, hit_rx;

  assign busy    = (state == ENG_RUN);
  assign xfer_tx = tx_head;
  assign step    = xfer_valid & xfer_ready;

  // decide, each running cycle, between finishing, stalling or offering a byte
  always_comb begin
    xfer_valid = 1'b0;
    seg_done   = 1'b0;
    hit_tx     = 1'b0;
    hit_rx     = 1'b0;
    if (busy) begin
      if (remain == '0) begin
        seg_done = 1'b1;
      end else if (tx_empty) begin
        seg_done = 1'b1;
        hit_tx   = 1'b1;
      end else if (rx_full) begin
        seg_done = 1'b1;
        hit_rx   = 1'b1;
      end else begin
        xfer_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      remain   <= '0;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else if (soft_rst) begin
      state    <= ENG_IDLE;
      remain   <= '0;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else if (go) begin
      state    <= ENG_RUN;
      remain   <= len;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else if (seg_done) begin
      state    <= ENG_IDLE;
      tx_stall <= tx_stall | hit_tx;
      rx_stall <= rx_stall | hit_rx;
    end else if (step) begin
      remain   <= remain - 1'b1;
    end
  end

  p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_tx)));

  p_stall_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stall || rx_stall) |-> !busy);

endmodule

// File: rtl/spi_seg_host.sv
module spi_seg_host
  import spi_seg_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_CS     = 4,
  parameter int LEN_W      = 8,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CW   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [5:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            xfer_valid,
  output logic [7:0]      xfer_tx,
  input  logic            xfer_ready,
  input  logic [7:0]      xfer_rx,
  output logic [CS_W-1:0] cs_index
);

  // named bus events
  logic wr_ctrl, wr_csid, wr_cmd, wr_txd, wr_err, rd_rxd;
  logic soft_rst, cmd_go, busy_hit, ovf_hit, unf_hit, csid_hit;

  logic            en_q;
  logic [E_W-1:0]  err_q;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [7:0]      tx_head;
  logic [31:0]     rx_peek, rx_word, stat;
  logic [2:0]      tx_push_n, rx_pop_n;
  logic [15:0]     tx_space;
  logic            busy, step, seg_done, tx_stall, rx_stall;
  logic            tx_empty, rx_full;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_csid = bus_wr && (bus_addr == A_CSID);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign wr_err  = bus_wr && (bus_addr == A_ERR);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);

  assign soft_rst = wr_ctrl && bus_wdata[C_RST];
  assign cmd_go   = wr_cmd && en_q && !busy;
  assign busy_hit = wr_cmd && en_q && busy;
  assign csid_hit = wr_csid && (bus_wdata >= 32'(NUM_CS));

  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (32'(rx_cnt) == FIFO_DEPTH);
  assign tx_space = 16'(FIFO_DEPTH) - 16'(tx_cnt);

  assign tx_push_n = wr_txd ? up_to_four(tx_space) : 3'd0;
  assign ovf_hit   = wr_txd && (tx_space < 16'd4);
  assign rx_pop_n  = rd_rxd ? up_to_four(16'(rx_cnt)) : 3'd0;
  assign unf_hit   = rd_rxd && (32'(rx_cnt) < 4);

  // ---------------- FIFOs ----------------
  spi_seg_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(4), .POP_W(1)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst | seg_done),
    .push_n    (tx_push_n),
    .push_data (bus_wdata),
    .pop_n     (step),
    .count     (tx_cnt),
    .peek      (tx_head)
  );

  spi_seg_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(1), .POP_W(4)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (soft_rst),
    .push_n    (step),
    .push_data (xfer_rx),
    .pop_n     (rx_pop_n),
    .count     (rx_cnt),
    .peek      (rx_peek)
  );

  // ---------------- segment engine ----------------
  spi_seg_engine #(.LEN_W(LEN_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .go         (cmd_go),
    .len        (bus_wdata[LEN_W-1:0]),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .tx_head    (tx_head),
    .xfer_ready (xfer_ready),
    .xfer_valid (xfer_valid),
    .xfer_tx    (xfer_tx),
    .step       (step),
    .busy       (busy),
    .seg_done   (seg_done),
    .tx_stall   (tx_stall),
    .rx_stall   (rx_stall)
  );

  // ---------------- control, chip select, errors ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cs_index <= '0;
      err_q    <= '0;
    end else if (soft_rst) begin
      en_q     <= 1'b0;
      cs_index <= '0;
      err_q    <= '0;
    end else begin
      if (wr_ctrl)
        en_q <= bus_wdata[C_EN];
      if (wr_csid && !csid_hit)
        cs_index <= bus_wdata[CS_W-1:0];
      err_q <= (err_q & ~(wr_err ? bus_wdata[E_W-1:0] : '0))
             | (E_W'(busy_hit) << E_BUSY)
             | (E_W'(ovf_hit)  << E_OVF)
             | (E_W'(unf_hit)  << E_UNF)
             | (E_W'(csid_hit) << E_CSID);
    end
  end

  // ---------------- read side ----------------
  always_comb begin
    for (int j = 0; j < 4; j++)
      rx_word[j*8 +: 8] = (j < int'(rx_cnt)) ? rx_peek[j*8 +: 8] : 8'h00;
  end

  always_comb begin
    stat            = '0;
    stat[S_READY]   = !busy;
    stat[S_ACTIVE]  = busy;
    stat[S_TXFULL]  = (32'(tx_cnt) == FIFO_DEPTH);
    stat[S_TXEMPTY] = tx_empty;
    stat[S_TXSTALL] = tx_stall;
    stat[S_RXFULL]  = rx_full;
    stat[S_RXEMPTY] = (rx_cnt == '0);
    stat[S_RXSTALL] = rx_stall;
    stat[15:8]      = words_up(16'(rx_cnt));
    stat[7:0]       = words_up(16'(tx_cnt));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {en_q, 31'b0};
        A_STAT:  bus_rdata = stat;
        A_CSID:  bus_rdata = 32'(cs_index);
        A_RXD:   bus_rdata = rx_word;
        A_ERR:   bus_rdata = 32'(err_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_cmd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !en_q && !busy) |=> !busy);

  p_cmdbusy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && !soft_rst) |=> err_q[E_BUSY]);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> (tx_cnt == '0));

  p_csid_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csid_hit && !soft_rst) |=> ($stable(cs_index) && err_q[E_CSID]));

  p_sw_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_cnt == '0 && rx_cnt == '0 && !busy && err_q == '0));

  p_ovf_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !soft_rst) |=> err_q[E_OVF]);

endmodule

// File: tb/spi_seg_host_tb_top.sv
module spi_seg_host_tb_top;

  localparam logic [5:0] R_CTRL = 6'h10, R_STAT = 6'h14, R_CSID = 6'h1C,
                         R_CMD  = 6'h20, R_TXD  = 6'h24, R_RXD  = 6'h28,
                         R_ERR  = 6'h30;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xfer_valid, xfer_ready;
  logic [7:0]  xfer_tx, xfer_rx;
  logic [1:0]  cs_index;

  always #4 clk = ~clk;

  spi_seg_host dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_valid(xfer_valid), .xfer_tx(xfer_tx), .xfer_ready(xfer_ready),
    .xfer_rx(xfer_rx), .cs_index(cs_index)
  );

  // responder on the shift port
  logic hold_low = 1'b0, throttle = 1'b0, phase = 1'b0;
  always @(posedge clk) phase <= ~phase;
  assign xfer_ready = hold_low ? 1'b0 : (throttle ? phase : 1'b1);
  assign xfer_rx    = xfer_tx ^ 8'hA5;

  int checks = 0, failures = 0;
  bit done = 0;
  bit en_model = 0;
  logic [7:0] mtx[$], mrx[$], tx_exp[$];
  logic [7:0] e_byte;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each exchanged byte against the queue
  always @(negedge clk) begin
    if (rst_n && xfer_valid && xfer_ready) begin
      checks++;
      if (tx_exp.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected exchange act=%h exp=none", xfer_tx);
      end else begin
        e_byte = tx_exp.pop_front();
        if (xfer_tx !== e_byte) begin
          failures++;
          $display("FAIL R1 byte order act=%h exp=%h", xfer_tx, e_byte);
        end
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(tag, v, exp);
  endtask

  // driver: model the TX FIFO, then write the word
  task automatic wr_tx(input logic [31:0] w);
    for (int i = 0; i < 4; i++)
      if (mtx.size() < DEPTH) mtx.push_back(w[i*8 +: 8]);
    bus_write(R_TXD, w);
  endtask

  // driver: predict the exchanged bytes, then issue the command
  task automatic start_cmd(input int len);
    if (en_model) begin
      for (int n = 0; n < len; n++) begin
        if (mtx.size() == 0) break;
        if (mrx.size() == DEPTH) break;
        e_byte = mtx.pop_front();
        tx_exp.push_back(e_byte);
        mrx.push_back(e_byte ^ 8'hA5);
      end
      mtx.delete();
    end
    bus_write(R_CMD, 32'(len));
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      bus_read(R_STAT, v);
      if (v[31]) break;
    end
  endtask

  task automatic rd_rx(input string tag);
    logic [31:0] exp, v;
    exp = '0;
    for (int i = 0; i < 4; i++)
      if (mrx.size() > 0) exp[i*8 +: 8] = mrx.pop_front();
    bus_read(R_RXD, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    chk_reg("R12 reset status", R_STAT, 32'h9100_0000);
    chk_reg("R13 reset errors", R_ERR, 32'h0);

    // R5: command ignored while disabled
    wr_tx(32'h4433_2211);
    start_cmd(4);
    repeat (6) @(posedge clk);
    chk_reg("R5 command ignored", R_STAT, 32'h8100_0001);

    // enable, second word, throttled full segment
    bus_write(R_CTRL, 32'h8000_0000);
    en_model = 1;
    wr_tx(32'h8877_6655);
    chk_reg("R12 two tx words", R_STAT, 32'h8100_0002);
    throttle = 1'b1;
    start_cmd(8);
    wait_ready();
    throttle = 1'b0;
    chk_reg("R7 eight bytes exchanged", R_STAT, 32'h9000_0200);
    chk_reg("R7 no errors", R_ERR, 32'h0);
    rd_rx("R3 rx word 0");
    rd_rx("R3 rx word 1");
    chk_reg("R3 rx drained", R_STAT, 32'h9100_0000);

    // R9 leftover flush, R12 rounding, R4 underflow
    wr_tx(32'h0403_0201);
    wr_tx(32'h0807_0605);
    wr_tx(32'h0C0B_0A09);
    start_cmd(5);
    wait_ready();
    chk_reg("R9 tx flushed, R12 rx rounded up", R_STAT, 32'h9000_0200);
    rd_rx("R3 full word");
    chk_reg("R4 no underflow yet", R_ERR, 32'h0);
    rd_rx("R4 partial word");
    chk_reg("R4 underflow flag", R_ERR, 32'h4);
    chk_reg("R4 rx empty", R_STAT, 32'h9100_0000);
    bus_write(R_ERR, 32'h4);
    chk_reg("R13 cleared", R_ERR, 32'h0);

    // R8 transmit stall
    wr_tx(32'hDEAD_BEEF);
    start_cmd(6);
    wait_ready();
    chk_reg("R8 tx stall", R_STAT, 32'h9800_0100);
    rd_rx("R8 stalled data");
    start_cmd(0);
    wait_ready();
    chk_reg("R8 stall cleared", R_STAT, 32'h9100_0000);

    // R6 busy command, R7 active
    hold_low = 1'b1;
    wr_tx(32'h1234_5678);
    start_cmd(2);
    chk_reg("R7 active while running", R_STAT, 32'h4100_0001);
    bus_write(R_CMD, 32'h3);
    chk_reg("R6 cmdbusy", R_ERR, 32'h1);
    hold_low = 1'b0;
    wait_ready();
    rd_rx("R6 two bytes");
    chk_reg("R13 two flags", R_ERR, 32'h5);
    bus_write(R_ERR, 32'h1);
    chk_reg("R13 selective clear", R_ERR, 32'h4);
    bus_write(R_ERR, 32'h4);

    // R2 overflow
    for (int w = 0; w < 64; w++) wr_tx(32'h0101_0101 * (w + 1));
    chk_reg("R2 no error when exactly full", R_ERR, 32'h0);
    chk_reg("R2 tx full", R_STAT, 32'hA100_0040);
    wr_tx(32'hFFFF_FFFF);
    chk_reg("R2 overflow flag", R_ERR, 32'h2);
    chk_reg("R2 depth unchanged", R_STAT, 32'hA100_0040);
    bus_write(R_ERR, 32'h2);

    // R8 receive stall
    start_cmd(200);
    wait_ready();
    chk_reg("R12 rx 200 bytes", R_STAT, 32'h9000_3200);
    for (int w = 0; w < 64; w++) wr_tx(32'h5A00_0000 + 32'(w));
    start_cmd(200);
    wait_ready();
    chk_reg("R8 rx stall", R_STAT, 32'h9280_4000);
    rd_rx("R3 read from full");
    chk_reg("R3 rxfull cleared", R_STAT, 32'h9080_3F00);

    // R10 chip select
    bus_write(R_CSID, 32'd2);
    chk_reg("R10 csid accepted", R_CSID, 32'd2);
    chk("R10 csid pin", 32'(cs_index), 32'd2);
    bus_write(R_CSID, 32'd4);
    chk_reg("R10 csid error", R_ERR, 32'h10);
    chk_reg("R10 csid kept", R_CSID, 32'd2);

    // R11 software reset
    wr_tx(32'h0BAD_F00D);
    bus_write(R_CTRL, 32'hC000_0000);
    mtx.delete(); mrx.delete(); en_model = 0;
    chk_reg("R11 status", R_STAT, 32'h9100_0000);
    chk_reg("R11 errors", R_ERR, 32'h0);
    chk_reg("R11 csid", R_CSID, 32'h0);
    chk_reg("R11 enable cleared", R_CTRL, 32'h0);

    chk("R7 all expected bytes seen", 32'(tx_exp.size()), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule